// File: doc/BRIEF.md
# Mirrored CPU Memory Bus Decoder

This block sits on the CPU side of a small 8-bit console-style system. The system has a 16-bit address and 8-bit data. Every access is sorted into one of four regions: work RAM, a peripheral register window, program ROM, or unmapped space. Each region folds the address in its own way. Work RAM (2 KB) answers at four aliased places across the bottom 8 KB. The register window has no peripheral behind it, so it reads as zero. Program ROM sits in the upper 32 KB. A 16 KB image repeats in both halves of that range, while a 32 KB image fills it straight.

The block holds both the work RAM and the ROM array. The ROM is filled through a byte-wide load port before the CPU starts issuing requests. Reads return data one cycle after the request. Writes into ROM space are refused and raise an error pulse. Any access to unmapped space raises its own pulse.

Top module: `cpu_bus_decode`

## Requirements
- R1: Addresses 0x0000–0x1FFF reach a 2048-byte work RAM indexed by address bits 10:0, so a byte written at one of the four aliases reads back at all four.
- R2: A read request (req_valid=1, req_we=0) yields rsp_valid=1 and its data exactly one cycle later. A write request or an idle cycle yields rsp_valid=0 in the following cycle.
- R3: Reads anywhere in 0x2000–0x3FFF return 0x00. Writes there change neither RAM nor ROM, and neither indication is raised.
- R4: With rom_size_32k=1, a read at 0x8000–0xFFFF returns the ROM byte at offset address−0x8000.
- R5: With rom_size_32k=0, offset bit 14 is ignored, so 0xC000+x returns the same byte as 0x8000+x.
- R6: A write in 0x8000–0xFFFF leaves ROM unchanged, gives rsp_valid=0, and pulses err_rom_write high in the cycle after the request.
- R7: Any access in 0x4000–0x7FFF pulses unmapped_hit high in the cycle after the request. A read there returns 0x00 with rsp_valid=1, and a write there changes nothing.
- R8: While rom_ld_en=1 and req_valid=0, rom_ld_data is stored at ROM offset rom_ld_off on each clock.
- R9: Reset (rst_n=0) clears the work RAM to zero and drives rsp_valid, rsp_rdata, err_rom_write and unmapped_hit to 0. ROM contents are kept.
- R10: Writing 0x55 to 0x0001 and then reading 0x0001 returns 0x55.
- R11: err_rom_write and unmapped_hit last one cycle only, and are low in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | CPU access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU byte address |
| req_wdata | input | 8 | Write data |
| rom_size_32k | input | 1 | 1 = 32 KB ROM image, 0 = 16 KB image mirrored |
| rom_ld_en | input | 1 | ROM load strobe, only while req_valid is low |
| rom_ld_off | input | ROM_STORE_AW | ROM byte offset to load |
| rom_ld_data | input | 8 | ROM byte to load |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 8 | Read data, zero when rsp_valid is low |
| err_rom_write | output | 1 | One-cycle pulse: a write targeted ROM space |
| unmapped_hit | output | 1 | One-cycle pulse: an access hit unmapped space |

## Verification
The hardest case to reach from the ports is telling the 16 KB mirror apart from the 32 KB linear map. That needs ROM contents whose upper and lower halves differ at every matching offset. To get there, the bench loads the full 32 KB array with a byte pattern that folds offset bit 14 into the data. It then reads the same upper-half addresses with the size select in both settings. RAM aliasing is reached the same way: a byte is written at one alias and read at the others. The bench also reads untouched RAM cells after writes to the register window, to show that those writes have no effect.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;

  localparam logic [CPU_AW-1:0] PERIPH_BASE = 16'h2000;
  localparam logic [CPU_AW-1:0] UNMAP_BASE  = 16'h4000;
  localparam logic [CPU_AW-1:0] ROM_BASE    = 16'h8000;
  localparam int                ROM_WIN_AW  = 15;

  typedef enum logic [1:0] {
    RGN_RAM      = 2'd0,
    RGN_PERIPH   = 2'd1,
    RGN_UNMAPPED = 2'd2,
    RGN_ROM      = 2'd3
  } region_e;
endpackage

// File: rtl/cbus_region_dec.sv
module cbus_region_dec
  import cbus_pkg::*;
#(
  parameter int RAM_AW       = 11,
  parameter int ROM_STORE_AW = 12
) (
  input  logic [CPU_AW-1:0]       addr,
  input  logic                    size_32k,
  output region_e                 region,
  output logic [RAM_AW-1:0]       ram_idx,
  output logic [ROM_STORE_AW-1:0] rom_idx
);
  logic [ROM_WIN_AW-1:0] rom_off;

  always_comb begin
    if (addr < PERIPH_BASE)     region = RGN_RAM;
    else if (addr < UNMAP_BASE) region = RGN_PERIPH;
    else if (addr < ROM_BASE)   region = RGN_UNMAPPED;
    else                        region = RGN_ROM;
  end

  // RAM alias: keep only the low index bits
  assign ram_idx = RAM_AW'(addr);

  // 16 KB image: drop offset bit 14 so the upper half repeats the lower
  assign rom_off = {addr[ROM_WIN_AW-1] & size_32k, addr[ROM_WIN_AW-2:0]};
  assign rom_idx = ROM_STORE_AW'(rom_off);
endmodule

// File: rtl/cbus_ram.sv
module cbus_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en) mem[idx] <= wdata;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cbus_rom.sv
module cbus_rom #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q, rdata_d;

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_data;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cpu_bus_decode.sv
module cpu_bus_decode
  import cbus_pkg::*;
#(
  parameter int RAM_AW       = 11,
  parameter int ROM_STORE_AW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [CPU_AW-1:0]       req_addr,
  input  logic [CPU_DW-1:0]       req_wdata,
  input  logic                    rom_size_32k,
  input  logic                    rom_ld_en,
  input  logic [ROM_STORE_AW-1:0] rom_ld_off,
  input  logic [CPU_DW-1:0]       rom_ld_data,
  output logic                    rsp_valid,
  output logic [CPU_DW-1:0]       rsp_rdata,
  output logic                    err_rom_write,
  output logic                    unmapped_hit
);
  region_e                 region;
  logic [RAM_AW-1:0]       ram_idx;
  logic [ROM_STORE_AW-1:0] rom_idx;
  logic [CPU_DW-1:0]       ram_rdata, rom_rdata;
  logic                    rd_req, wr_req;

  assign rd_req = req_valid & ~req_we;
  assign wr_req = req_valid &  req_we;

  cbus_region_dec #(.RAM_AW(RAM_AW), .ROM_STORE_AW(ROM_STORE_AW)) u_dec (
    .addr     (req_addr),
    .size_32k (rom_size_32k),
    .region   (region),
    .ram_idx  (ram_idx),
    .rom_idx  (rom_idx)
  );

  cbus_ram #(.AW(RAM_AW), .DW(CPU_DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_req && region == RGN_RAM),
    .rd_en (rd_req && region == RGN_RAM),
    .idx   (ram_idx),
    .wdata (req_wdata),
    .rdata (ram_rdata)
  );

  cbus_rom #(.AW(ROM_STORE_AW), .DW(CPU_DW)) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (rom_ld_en),
    .ld_idx  (rom_ld_off),
    .ld_data (rom_ld_data),
    .rd_en   (rd_req && region == RGN_ROM),
    .rd_idx  (rom_idx),
    .rdata   (rom_rdata)
  );

  // Response stage: next-state / register split
  logic    vld_q, vld_d;
  logic    err_q, err_d;
  logic    unm_q, unm_d;
  region_e rgn_q, rgn_d;

  always_comb begin
    vld_d = rd_req;
    err_d = wr_req && region == RGN_ROM;
    unm_d = req_valid && region == RGN_UNMAPPED;
    rgn_d = rgn_q;
    if (req_valid) rgn_d = region;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      unm_q <= 1'b0;
      rgn_q <= RGN_UNMAPPED;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
      unm_q <= unm_d;
      rgn_q <= rgn_d;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (vld_q) begin
      case (rgn_q)
        RGN_RAM: rsp_rdata = ram_rdata;
        RGN_ROM: rsp_rdata = rom_rdata;
        default: rsp_rdata = '0;
      endcase
    end
  end

  assign rsp_valid     = vld_q;
  assign err_rom_write = err_q;
  assign unmapped_hit  = unm_q;

  // R2: a read is answered in the next cycle
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);
  // R2: writes produce no response strobe
  a_r2_no_rsp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> !rsp_valid);
  // R3: register window reads as zero
  a_r3_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rgn_q == RGN_PERIPH) |-> rsp_rdata == '0);
  // R6: a ROM-space write raises the error in the next cycle
  a_r6_rom_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_addr >= ROM_BASE) |=> err_rom_write);
  // R7: unmapped reads return zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_hit && rsp_valid) |-> rsp_rdata == '0);
  // R8: loading happens only while the CPU port is idle
  a_r8_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ld_en |-> !req_valid);
  // R11: indications are pulses and never both at once
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !err_rom_write && !unmapped_hit);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_rom_write, unmapped_hit}));
endmodule

// File: tb/test_cpu_bus_decode.sv
module test_cpu_bus_decode;
  localparam int ROM_AW = 15;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_we, rom_size_32k, rom_ld_en;
  logic [15:0]       req_addr;
  logic [7:0]        req_wdata, rom_ld_data;
  logic [ROM_AW-1:0] rom_ld_off;
  logic              rsp_valid, err_rom_write, unmapped_hit;
  logic [7:0]        rsp_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  cpu_bus_decode #(.RAM_AW(11), .ROM_STORE_AW(ROM_AW)) i_cpu_bus_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rom_size_32k(rom_size_32k),
    .rom_ld_en(rom_ld_en), .rom_ld_off(rom_ld_off), .rom_ld_data(rom_ld_data),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_rom_write(err_rom_write), .unmapped_hit(unmapped_hit)
  );

  // ROM fill pattern: bit 14 of the offset changes the byte
  function automatic logic [7:0] pat(input logic [14:0] o);
    return o[7:0] ^ {1'b0, o[14:8]};
  endfunction

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  typedef struct packed {
    logic [15:0] a;
    logic        we;
    logic [7:0]  wd;
    logic [7:0]  ed;
    logic        ev;
    logic        ee;
    logic        eu;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{16'h0001, 1'b1, 8'h55, 8'h00, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 write
    '{16'h0001, 1'b0, 8'h00, 8'h55, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 read back
    '{16'h0801, 1'b0, 8'h00, 8'h55, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 alias
    '{16'h1801, 1'b0, 8'h00, 8'h55, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 alias
    '{16'h17FF, 1'b1, 8'hA5, 8'h00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 write no rsp
    '{16'h07FF, 1'b0, 8'h00, 8'hA5, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 alias
    '{16'h2003, 1'b1, 8'h99, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 window write
    '{16'h2003, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 window read
    '{16'h3FFF, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 window top
    '{16'h0003, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 RAM untouched
    '{16'h4000, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 read
    '{16'h7FFF, 1'b1, 8'h12, 8'h00, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 write
    '{16'h8000, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{16'hC000, 1'b0, 8'h00, 8'h40, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 linear
    '{16'hFFFF, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 top
    '{16'h8005, 1'b1, 8'hEE, 8'h00, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 write
    '{16'h8005, 1'b0, 8'h00, 8'h05, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 unchanged
    '{16'h1234, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd9}   // R9 cleared cell
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    rom_size_32k = 1'b1; rom_ld_en = 1'b0; rom_ld_off = '0; rom_ld_data = '0;
    repeat (2) @(negedge clk);
    // R9: reset state
    chk("R9 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    chk("R9 rsp_rdata", rsp_rdata, 8'h00);
    chk("R9 flags", {6'd0, err_rom_write, unmapped_hit}, 8'h00);
    rst_n = 1'b1;

    // R8: fill the whole ROM
    for (int o = 0; o < (1 << ROM_AW); o++) begin
      @(negedge clk);
      rom_ld_en = 1'b1; rom_ld_off = ROM_AW'(o); rom_ld_data = pat(15'(o));
    end
    @(negedge clk);
    rom_ld_en = 1'b0;

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].a, VEC[i].we, VEC[i].wd);
      chk($sformatf("R%0d v%0d rdata", VEC[i].rq, i), rsp_rdata, VEC[i].ed);
      chk($sformatf("R%0d v%0d valid", VEC[i].rq, i), {7'd0, rsp_valid}, {7'd0, VEC[i].ev});
      chk($sformatf("R%0d v%0d err", VEC[i].rq, i), {7'd0, err_rom_write}, {7'd0, VEC[i].ee});
      chk($sformatf("R%0d v%0d unm", VEC[i].rq, i), {7'd0, unmapped_hit}, {7'd0, VEC[i].eu});
    end

    // R11: pulse drops after an idle cycle
    acc(16'h9000, 1'b1, 8'h01);
    chk("R11 err pulse", {7'd0, err_rom_write}, 8'h01);
    @(negedge clk);
    chk("R11 err cleared", {7'd0, err_rom_write}, 8'h00);
    acc(16'h5000, 1'b0, 8'h00);
    @(negedge clk);
    chk("R11 unm cleared", {7'd0, unmapped_hit}, 8'h00);
    chk("R2 idle no rsp", {7'd0, rsp_valid}, 8'h00);

    // R5: 16 KB image mirrors
    rom_size_32k = 1'b0;
    acc(16'hC000, 1'b0, 8'h00);
    chk("R5 C000", rsp_rdata, pat(15'h0000));
    acc(16'hFFFF, 1'b0, 8'h00);
    chk("R5 FFFF", rsp_rdata, pat(15'h3FFF));
    acc(16'hC123, 1'b0, 8'h00);
    chk("R5 C123", rsp_rdata, pat(15'h0123));
    rom_size_32k = 1'b1;
    acc(16'hC123, 1'b0, 8'h00);
    chk("R4 C123 linear", rsp_rdata, pat(15'h4123));

    // R8: reload one byte
    @(negedge clk);
    rom_ld_en = 1'b1; rom_ld_off = 15'h0010; rom_ld_data = 8'h3C;
    @(negedge clk);
    rom_ld_en = 1'b0;
    acc(16'h8010, 1'b0, 8'h00);
    chk("R8 reload", rsp_rdata, 8'h3C);

    // R9: second reset clears RAM, keeps ROM
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    acc(16'h0001, 1'b0, 8'h00);
    chk("R9 RAM cleared", rsp_rdata, 8'h00);
    acc(16'h8010, 1'b0, 8'h00);
    chk("R9 ROM kept", rsp_rdata, 8'h3C);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule